// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder

This block decodes 16-bit instruction words whose opcode field grows as the number of address fields shrinks. Words with a 4-bit opcode carry three 4-bit address fields. Escape patterns in the upper nibbles extend the opcode to 8, 12 and finally 16 bits. Each step gives up one address field. The decoder reports which of the four classes a word belongs to and the opcode index within that class. It also unpacks the address fields that class carries and drives the fields it does not carry to zero.

Words enter one per cycle on a valid/ready handshake. Each accepted word produces one registered result, which is presented on a valid/ready output. The result register refills in the same cycle it is drained, so a stream with no stalls sustains one word per cycle. Under backpressure the result is held steady and the input is refused. Parameters set how many opcodes are implemented in each class. A word that decodes to an index at or above its class's count is flagged illegal.

Top module: `exp_opcode_decoder`

## Requirements
- R1: A word whose bits 15:12 are 0x0 to 0xE is class code 0 (three-address), with index = bits 15:12, field A = bits 11:8, field B = bits 7:4 and field C = bits 3:0.
- R2: A word with bits 15:12 = 0xF and bits 11:8 = 0x0 to 0xD is class code 1 (two-address), with index = bits 11:8, A = bits 7:4, B = bits 3:0 and C = 0.
- R3: A word with bits 15:9 all ones and bits 15:4 not equal to 0xFFF is class code 2 (one-address), with index = {bit 8, bits 7:4}, a value from 0 to 30, A = bits 3:0 and B = C = 0.
- R4: A word with bits 15:4 = 0xFFF is class code 3 (zero-address), with index = bits 3:0 and A = B = C = 0.
- R5: When the index is at or above the implemented opcode count parameter of its class, the illegal flag is 1 and A, B and C are 0. Class and index are still reported.
- R6: While reset is asserted and after it is released, out_valid_o is 0 and in_ready_o is 1.
- R7: in_ready_o is 1 exactly when the output holds no result or out_ready_i is 1.
- R8: A word accepted at a clock edge appears on the outputs with out_valid_o = 1 after that edge. While out_ready_i is 0 the result and out_valid_o stay unchanged.
- R9: Each accepted word yields exactly one output transfer, in acceptance order, including when a drain and a new acceptance happen at the same edge.
- R10: With in_valid_i and out_ready_i held at 1, one word is accepted and one result is delivered every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Decoder can accept a word |
| in_word_i | input | 16 | Instruction word |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts the result |
| cls_o | output | 2 | Class code: 0 three-, 1 two-, 2 one-, 3 zero-address |
| idx_o | output | 5 | Opcode index within the class |
| illegal_o | output | 1 | Index not implemented in its class |
| addr_a_o | output | 4 | First address field |
| addr_b_o | output | 4 | Second address field |
| addr_c_o | output | 4 | Third address field |

## Verification
The two functions that can coincide are the handover of a held result and the acceptance of the next word. Both happen at the edge where out_ready_i returns high while in_valid_i is already asserted. The bench stalls the output with a result inside, keeps the next word waiting, and checks that the held result stays stable. It then releases the stall and checks that the new word shows up exactly one edge later with nothing lost or repeated. A back-to-back stream with both handshakes held high repeats this overlap on every edge, and the bench compares each delivered result against the word sent one cycle earlier.

// File: rtl/exp_dec_pkg.sv
package exp_dec_pkg;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    CLS_3A = 2'd0,
    CLS_2A = 2'd1,
    CLS_1A = 2'd2,
    CLS_0A = 2'd3
  } insn_cls_e;

  typedef struct packed {
    insn_cls_e          cls;
    logic [IDX_W-1:0]   idx;
    logic               illegal;
    logic [NIB_W-1:0]   fa;
    logic [NIB_W-1:0]   fb;
    logic [NIB_W-1:0]   fc;
  } dec_res_t;
endpackage

// File: rtl/exp_dec_classify.sv
module exp_dec_classify
  import exp_dec_pkg::*;
#(
  parameter int N_OPS_3A = 15,
  parameter int N_OPS_2A = 14,
  parameter int N_OPS_1A = 31,
  parameter int N_OPS_0A = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output insn_cls_e         cls_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              illegal_o
);
  localparam int NIBS = WORD_W / NIB_W;

  logic [NIB_W-1:0] nib [NIBS];

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib[g] = word_i[g*NIB_W +: NIB_W];
  end

  // escape chain: each level widens the opcode by one nibble
  logic esc_hi, esc_mid, esc_lo;
  assign esc_hi  = &nib[NIBS-1];
  assign esc_mid = esc_hi & (&nib[NIBS-2][NIB_W-1:1]);
  assign esc_lo  = esc_mid & nib[NIBS-2][0] & (&nib[NIBS-3]);

  always_comb begin
    if (!esc_hi) begin
      cls_o = CLS_3A;
      idx_o = IDX_W'(nib[NIBS-1]);
    end else if (!esc_mid) begin
      cls_o = CLS_2A;
      idx_o = IDX_W'(nib[NIBS-2]);
    end else if (!esc_lo) begin
      cls_o = CLS_1A;
      idx_o = IDX_W'({nib[NIBS-2][0], nib[NIBS-3]});
    end else begin
      cls_o = CLS_0A;
      idx_o = IDX_W'(nib[0]);
    end
  end

  logic [IDX_W:0] limit;
  always_comb begin
    unique case (cls_o)
      CLS_3A:  limit = (IDX_W+1)'(N_OPS_3A);
      CLS_2A:  limit = (IDX_W+1)'(N_OPS_2A);
      CLS_1A:  limit = (IDX_W+1)'(N_OPS_1A);
      default: limit = (IDX_W+1)'(N_OPS_0A);
    endcase
  end

  assign illegal_o = {1'b0, idx_o} >= limit;
endmodule

// File: rtl/exp_dec_fields.sv
module exp_dec_fields
  import exp_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  insn_cls_e         cls_i,
  input  logic              illegal_i,
  output logic [NIB_W-1:0]  fa_o,
  output logic [NIB_W-1:0]  fb_o,
  output logic [NIB_W-1:0]  fc_o
);
  localparam int NIBS = WORD_W / NIB_W;

  logic [NIB_W-1:0] nib [NIBS-1];

  for (genvar g = 0; g < NIBS-1; g++) begin : g_nib
    assign nib[g] = word_i[g*NIB_W +: NIB_W];
  end

  always_comb begin
    fa_o = '0;
    fb_o = '0;
    fc_o = '0;
    if (!illegal_i) begin
      unique case (cls_i)
        CLS_3A: begin
          fa_o = nib[2];
          fb_o = nib[1];
          fc_o = nib[0];
        end
        CLS_2A: begin
          fa_o = nib[1];
          fb_o = nib[0];
        end
        CLS_1A:  fa_o = nib[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exp_dec_out_reg.sv
module exp_dec_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // refill allowed when empty or being drained this edge
  assign load       = !valid_q || out_ready_i;
  assign in_ready_o = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/exp_opcode_decoder.sv
module exp_opcode_decoder
  import exp_dec_pkg::*;
#(
  parameter int N_OPS_3A = 15,
  parameter int N_OPS_2A = 14,
  parameter int N_OPS_1A = 31,
  parameter int N_OPS_0A = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        cls_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              illegal_o,
  output logic [NIB_W-1:0]  addr_a_o,
  output logic [NIB_W-1:0]  addr_b_o,
  output logic [NIB_W-1:0]  addr_c_o
);
  localparam int RES_W = $bits(dec_res_t);

  dec_res_t d_res, q_res;

  exp_dec_classify #(
    .N_OPS_3A(N_OPS_3A),
    .N_OPS_2A(N_OPS_2A),
    .N_OPS_1A(N_OPS_1A),
    .N_OPS_0A(N_OPS_0A)
  ) u_cls (
    .word_i   (in_word_i),
    .cls_o    (d_res.cls),
    .idx_o    (d_res.idx),
    .illegal_o(d_res.illegal)
  );

  exp_dec_fields u_fld (
    .word_i   (in_word_i),
    .cls_i    (d_res.cls),
    .illegal_i(d_res.illegal),
    .fa_o     (d_res.fa),
    .fb_o     (d_res.fb),
    .fc_o     (d_res.fc)
  );

  exp_dec_out_reg #(.DATA_W(RES_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (d_res),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (q_res)
  );

  assign cls_o     = q_res.cls;
  assign idx_o     = q_res.idx;
  assign illegal_o = q_res.illegal;
  assign addr_a_o  = q_res.fa;
  assign addr_b_o  = q_res.fb;
  assign addr_c_o  = q_res.fc;
endmodule

// File: rtl/exp_opcode_decoder_checker.sv
module exp_opcode_decoder_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [1:0] cls_o,
  input logic [4:0] idx_o,
  input logic       illegal_o,
  input logic [3:0] addr_a_o,
  input logic [3:0] addr_b_o,
  input logic [3:0] addr_c_o
);
  assert_three_addr_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cls_o == 2'd0) |-> idx_o < 5'd15);

  assert_two_addr_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cls_o == 2'd1) |-> (idx_o < 5'd14 && addr_c_o == 4'd0));

  assert_one_addr_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cls_o == 2'd2) |-> (idx_o <= 5'd30 && addr_b_o == 4'd0 && addr_c_o == 4'd0));

  assert_zero_addr_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cls_o == 2'd3) |-> (idx_o < 5'd16 && addr_a_o == 4'd0 && addr_b_o == 4'd0 && addr_c_o == 4'd0));

  assert_illegal_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |-> (addr_a_o == 4'd0 && addr_b_o == 4'd0 && addr_c_o == 4'd0));

  assert_stall_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_accept_shows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(cls_o) && $stable(idx_o)
      && $stable(illegal_o) && $stable(addr_a_o) && $stable(addr_b_o) && $stable(addr_c_o)));

  assert_drain_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);
endmodule

bind exp_opcode_decoder exp_opcode_decoder_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .cls_o      (cls_o),
  .idx_o      (idx_o),
  .illegal_o  (illegal_o),
  .addr_a_o   (addr_a_o),
  .addr_b_o   (addr_b_o),
  .addr_c_o   (addr_c_o)
);

// File: tb/exp_opcode_decoder_test.sv
module exp_opcode_decoder_test;
  localparam int NV    = 16;
  localparam int EXP_W = 20;

  // bench build: two-address opcodes 12,13 and zero-address 12..15 unimplemented
  localparam logic [15:0] VEC_W [NV] = '{
    16'h3456, 16'h0000, 16'hE9AB, 16'hF0C7,
    16'hFB12, 16'hFC34, 16'hFD99, 16'hFE05,
    16'hFE7A, 16'hFF3C, 16'hFFE1, 16'hFFF0,
    16'hFFFB, 16'hFFFC, 16'hFFFF, 16'hFEF3
  };
  // {cls, idx, illegal, a, b, c}
  localparam logic [EXP_W-1:0] VEC_E [NV] = '{
    {2'd0, 5'd3,  1'b0, 4'h4, 4'h5, 4'h6},
    {2'd0, 5'd0,  1'b0, 4'h0, 4'h0, 4'h0},
    {2'd0, 5'd14, 1'b0, 4'h9, 4'hA, 4'hB},
    {2'd1, 5'd0,  1'b0, 4'hC, 4'h7, 4'h0},
    {2'd1, 5'd11, 1'b0, 4'h1, 4'h2, 4'h0},
    {2'd1, 5'd12, 1'b1, 4'h0, 4'h0, 4'h0},
    {2'd1, 5'd13, 1'b1, 4'h0, 4'h0, 4'h0},
    {2'd2, 5'd0,  1'b0, 4'h5, 4'h0, 4'h0},
    {2'd2, 5'd7,  1'b0, 4'hA, 4'h0, 4'h0},
    {2'd2, 5'd19, 1'b0, 4'hC, 4'h0, 4'h0},
    {2'd2, 5'd30, 1'b0, 4'h1, 4'h0, 4'h0},
    {2'd3, 5'd0,  1'b0, 4'h0, 4'h0, 4'h0},
    {2'd3, 5'd11, 1'b0, 4'h0, 4'h0, 4'h0},
    {2'd3, 5'd12, 1'b1, 4'h0, 4'h0, 4'h0},
    {2'd3, 5'd15, 1'b1, 4'h0, 4'h0, 4'h0},
    {2'd2, 5'd15, 1'b0, 4'h3, 4'h0, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [15:0] in_word = '0;
  logic in_ready, out_valid, illegal;
  logic [1:0] cls;
  logic [4:0] idx;
  logic [3:0] fa, fb, fc;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exp_opcode_decoder #(.N_OPS_2A(12), .N_OPS_0A(12)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .cls_o(cls), .idx_o(idx), .illegal_o(illegal),
    .addr_a_o(fa), .addr_b_o(fb), .addr_c_o(fc)
  );

  wire [EXP_W-1:0] obs = {cls, idx, illegal, fa, fb, fc};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [EXP_W-1:0] e);
    if (e[12]) return "R5";
    case (e[19:18])
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R6: reset state
    #12;
    chk("R6", "valid in reset", 32'(out_valid), 32'd0);
    chk("R6", "ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "valid after reset", 32'(out_valid), 32'd0);
    chk("R6", "ready after reset", 32'(in_ready), 32'd1);

    // table walk, one word at a time
    for (int i = 0; i < NV; i++) begin
      in_word  = VEC_W[i];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8", "valid after accept", 32'(out_valid), 32'd1);
      chk(req_of(VEC_E[i]), $sformatf("decode %h", VEC_W[i]), 32'(obs), 32'(VEC_E[i]));
      @(negedge clk);
      chk("R9", "drained once", 32'(out_valid), 32'd0);
    end

    // stall: hold A, offer B, then release so drain and refill coincide
    out_ready = 1'b0;
    in_word   = VEC_W[0];
    in_valid  = 1'b1;
    @(negedge clk);
    in_word = VEC_W[4];
    chk("R7", "ready while stalled", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8", "valid held", 32'(out_valid), 32'd1);
    chk("R8", "result held", 32'(obs), 32'(VEC_E[0]));
    out_ready = 1'b1;
    #1;
    chk("R7", "ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "refill valid", 32'(out_valid), 32'd1);
    chk("R9", "refill result", 32'(obs), 32'(VEC_E[4]));
    @(negedge clk);
    chk("R9", "no duplicate", 32'(out_valid), 32'd0);

    // back-to-back stream
    in_valid = 1'b1;
    in_word  = VEC_W[3];
    @(negedge clk);
    chk("R10", "stream ready", 32'(in_ready), 32'd1);
    chk("R10", "stream 0", 32'(obs), 32'(VEC_E[3]));
    in_word = VEC_W[7];
    @(negedge clk);
    chk("R10", "stream 1", 32'(obs), 32'(VEC_E[7]));
    in_word = VEC_W[11];
    @(negedge clk);
    chk("R10", "stream 2", 32'(obs), 32'(VEC_E[11]));
    in_word = VEC_W[1];
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "stream 3", 32'(obs), 32'(VEC_E[1]));
    chk("R10", "stream valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R9", "stream end", 32'(out_valid), 32'd0);

    // reset mid-hold clears output
    out_ready = 1'b0;
    in_word   = VEC_W[2];
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    chk("R6", "valid cleared by reset", 32'(out_valid), 32'd0);
    chk("R6", "ready under reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n     = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule